// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key with an 8-bit datapath. The key and the plaintext arrive together, one byte of each per cycle, while the core is idle. A start pulse then runs the ten rounds, and the ciphertext leaves one byte per cycle. The state and the round key are kept in byte-wide shift registers. Substitution, AddRoundKey and the on-the-fly key schedule all advance one byte per cycle.

A single substitution box is time-shared. It serves state bytes during the substitution pass and the four key bytes of the schedule's word substitution during the column-mixing pass. ShiftRows has no logic of its own: it is a one-cycle load of the state register along permuted paths. MixColumns handles one 32-bit column per cycle. Both registers take an update only when the current phase needs one, so they stay still while the core is idle.

Every block takes the same number of cycles, whatever the key and data values.

Top module: `aesb8_core`

## Requirements
- R1: After reset, `busy` and `dout_valid` are both low.
- R2: While `busy` is low, each cycle with `din_valid` high shifts in one key byte from `key_in` and one plaintext byte from `din`. The last 16 such bytes form the key and the block, and the first byte is the most significant one (byte 0 in standard AES byte order).
- R3: The output block equals the AES-128 encryption (ten rounds, last round without MixColumns) of the loaded plaintext under the loaded key.
- R4: Each block is presented on `dout` in exactly 16 consecutive cycles with `dout_valid` high, most significant byte first. `dout_valid` is low at every other time.
- R5: The first `dout_valid` cycle appears exactly 211 clock edges after the edge that accepts `start`, for any key and data.
- R6: `busy` goes high at the edge that accepts `start` and stays high until the edge that presents the last ciphertext byte, where it falls.
- R7: `start` and `din_valid` have no effect while `busy` is high.
- R8: While `busy` and `din_valid` are both low, the loaded key and block hold unchanged, so `start` may follow the load after any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin encrypting the loaded block (taken only when idle) |
| key_in | input | 8 | Key byte, taken with `din_valid` |
| din | input | 8 | Plaintext byte, taken with `din_valid` |
| din_valid | input | 1 | Load strobe for `key_in` and `din` while idle |
| dout | output | 8 | Ciphertext byte |
| dout_valid | output | 1 | `dout` holds a ciphertext byte |
| busy | output | 1 | An encryption is in progress |

## Verification
Three known-answer blocks are run: an all-zero key and plaintext, a counting key with a patterned plaintext, and a block with irregular bytes in both. The all-zero case checks the substitution and round constants without help from the data. The other two exercise every MixColumns coefficient and both byte orders. One block waits idle between load and start, so a register that drifts while idle shows up as a wrong ciphertext. During two blocks, stray load strobes and start pulses are driven while the core is busy, and these would corrupt the result or the latency if they were not ignored. The latency and the valid run length are measured for every block, so a data-dependent schedule or a short output burst is caught.

// File: rtl/aesb8_pkg.sv
package aesb8_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SUB,
      PH_ROT,
      PH_MIX,
      PH_OUT
   } phase_t;

   // multiply by x modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] xt(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p;
      logic [7:0] aa;
      p  = 8'h00;
      aa = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ aa;
         aa = xt(aa);
      end
      return p;
   endfunction

   // multiplicative inverse as x^254 (zero maps to zero)
   function automatic logic [7:0] ginv(input logic [7:0] x);
      logic [7:0] r;
      logic [7:0] base;
      r    = 8'h01;
      base = x;
      for (int i = 0; i < 8; i++) begin
         if (i != 0) r = gmul(r, base);
         base = gmul(base, base);
      end
      return r;
   endfunction

   function automatic logic [7:0] sbox(input logic [7:0] x);
      logic [7:0] b;
      b = ginv(x);
      return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
               ^ {b[3:0], b[7:4]} ^ 8'h63;
   endfunction

endpackage

// File: rtl/aesb8_ctrl.sv
module aesb8_ctrl
   import aesb8_pkg::*;
#(
   parameter int NBYTES  = 16,
   parameter int NROUNDS = 10,
   parameter int CW      = $clog2(NBYTES),
   parameter int RW      = $clog2(NROUNDS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output phase_t        ph,
   output logic [CW-1:0] cnt,
   output logic [RW-1:0] rnd,
   output logic [7:0]    rcon,
   output logic          last_rnd
);

   localparam int COLS = NBYTES / 4;

   assign last_rnd = (rnd == RW'(NROUNDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         cnt  <= '0;
         rnd  <= RW'(1);
         rcon <= 8'h01;
      end else begin
         case (ph)
            PH_IDLE: if (start) begin
               ph   <= PH_SUB;
               cnt  <= '0;
               rnd  <= RW'(1);
               rcon <= 8'h01;
            end
            PH_SUB: begin
               cnt <= cnt + CW'(1);
               if (cnt == CW'(NBYTES - 1)) begin
                  ph  <= PH_ROT;
                  cnt <= '0;
               end
            end
            PH_ROT: begin
               ph  <= PH_MIX;
               cnt <= '0;
            end
            PH_MIX: begin
               cnt <= cnt + CW'(1);
               if (cnt == CW'(COLS - 1)) begin
                  cnt  <= '0;
                  rcon <= xt(rcon);
                  if (last_rnd) begin
                     ph <= PH_OUT;
                  end else begin
                     ph  <= PH_SUB;
                     rnd <= rnd + RW'(1);
                  end
               end
            end
            PH_OUT: begin
               cnt <= cnt + CW'(1);
               if (cnt == CW'(NBYTES - 1)) begin
                  ph  <= PH_IDLE;
                  cnt <= '0;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/aesb8_mixcol.sv
module aesb8_mixcol
   import aesb8_pkg::*;
(
   input  logic [7:0] a [4],
   output logic [7:0] b [4]
);

   for (genvar r = 0; r < 4; r++) begin : g_row
      assign b[r] = xt(a[r]) ^ xt(a[(r + 1) % 4]) ^ a[(r + 1) % 4]
                  ^ a[(r + 2) % 4] ^ a[(r + 3) % 4];
   end

endmodule

// File: rtl/aesb8_state.sv
module aesb8_state
   import aesb8_pkg::*;
#(
   parameter int NBYTES = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  phase_t              ph,
   input  logic                load,
   input  logic [7:0]          din,
   input  logic [7:0]          sub_in,
   input  logic                last_rnd,
   output logic [7:0]          head,
   output logic [8*NBYTES-1:0] flat
);

   logic [7:0] s     [NBYTES];
   logic [7:0] s_nx  [NBYTES];
   logic [7:0] s_rot [NBYTES];
   logic [7:0] col   [4];
   logic [7:0] mixed [4];
   logic       en;

   // ShiftRows as permuted load paths: row r of column c takes column (c+r) mod 4
   for (genvar j = 0; j < NBYTES; j++) begin : g_rot
      localparam int ROW = j % 4;
      localparam int CL  = j / 4;
      localparam int SRC = 4 * ((CL + ROW) % 4) + ROW;
      assign s_rot[j] = s[SRC];
      assign flat[8*(NBYTES-1-j) +: 8] = s[j];
   end

   for (genvar r = 0; r < 4; r++) begin : g_col
      assign col[r] = s[r];
   end

   aesb8_mixcol u_mix (.a(col), .b(mixed));

   assign head = s[0];
   assign en   = load || (ph != PH_IDLE);

   always_comb begin
      s_nx = s;
      case (ph)
         PH_IDLE: if (load) begin
            for (int j = 0; j < NBYTES - 1; j++) s_nx[j] = s[j+1];
            s_nx[NBYTES-1] = din;
         end
         PH_SUB: begin
            for (int j = 0; j < NBYTES - 1; j++) s_nx[j] = s[j+1];
            s_nx[NBYTES-1] = sub_in;
         end
         PH_ROT: s_nx = s_rot;
         PH_MIX: begin
            for (int j = 0; j < NBYTES - 4; j++) s_nx[j] = s[j+4];
            for (int r = 0; r < 4; r++) s_nx[NBYTES-4+r] = last_rnd ? s[r] : mixed[r];
         end
         PH_OUT: begin
            for (int j = 0; j < NBYTES - 1; j++) s_nx[j] = s[j+1];
            s_nx[NBYTES-1] = s[0];
         end
         default: s_nx = s;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < NBYTES; j++) s[j] <= 8'h00;
      end else if (en) begin
         s <= s_nx;
      end
   end

endmodule

// File: rtl/aesb8_key.sv
module aesb8_key
   import aesb8_pkg::*;
#(
   parameter int NBYTES = 16,
   parameter int CW     = $clog2(NBYTES),
   parameter int RW     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  phase_t              ph,
   input  logic                load,
   input  logic [7:0]          key_in,
   input  logic [CW-1:0]       cnt,
   input  logic [RW-1:0]       rnd,
   input  logic [7:0]          rcon,
   input  logic [7:0]          sub_in,
   output logic [7:0]          kx,
   output logic [7:0]          sb_key,
   output logic [8*NBYTES-1:0] flat
);

   logic [7:0] k    [NBYTES];
   logic [7:0] k_nx [NBYTES];
   logic       pend;
   logic       en;
   logic [1:0] nxt;
   logic [3:0] widx;

   for (genvar j = 0; j < NBYTES; j++) begin : g_flat
      assign flat[8*(NBYTES-1-j) +: 8] = k[j];
   end

   // bytes 4..15 of the next round key are finished in step with the byte pass;
   // the finished byte four places earlier sits at index 12
   assign pend   = (ph == PH_OUT) || (rnd != RW'(1));
   assign kx     = (pend && (cnt >= CW'(4))) ? (k[0] ^ k[NBYTES-4]) : k[0];
   assign nxt    = cnt[1:0] + 2'd1;
   assign sb_key = k[{2'b11, nxt}];
   assign widx   = {2'b00, cnt[1:0]};
   assign en     = load || (ph == PH_SUB) || (ph == PH_MIX) || (ph == PH_OUT);

   always_comb begin
      k_nx = k;
      case (ph)
         PH_IDLE: if (load) begin
            for (int j = 0; j < NBYTES - 1; j++) k_nx[j] = k[j+1];
            k_nx[NBYTES-1] = key_in;
         end
         PH_SUB, PH_OUT: begin
            for (int j = 0; j < NBYTES - 1; j++) k_nx[j] = k[j+1];
            k_nx[NBYTES-1] = kx;
         end
         PH_MIX: k_nx[widx] = k[widx] ^ sub_in ^ ((cnt == '0) ? rcon : 8'h00);
         default: k_nx = k;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < NBYTES; j++) k[j] <= 8'h00;
      end else if (en) begin
         k <= k_nx;
      end
   end

endmodule

// File: rtl/aesb8_core.sv
module aesb8_core
   import aesb8_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int NBYTES  = 16,
   parameter int NROUNDS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BYTE_W-1:0] key_in,
   input  logic [BYTE_W-1:0] din,
   input  logic              din_valid,
   output logic [BYTE_W-1:0] dout,
   output logic              dout_valid,
   output logic              busy
);

   localparam int CW = $clog2(NBYTES);
   localparam int RW = $clog2(NROUNDS + 1);

   initial begin
      assert (BYTE_W == 8)   else $fatal(1, "BYTE_W must be 8");
      assert (NBYTES == 16)  else $fatal(1, "NBYTES must be 16");
      assert (NROUNDS == 10) else $fatal(1, "NROUNDS must be 10");
   end

   phase_t              ph;
   logic [CW-1:0]       cnt;
   logic [RW-1:0]       rnd;
   logic [7:0]          rcon;
   logic                last_rnd;
   logic                load;
   logic [7:0]          s_head;
   logic [7:0]          kx;
   logic [7:0]          sb_key;
   logic [7:0]          sb_in;
   logic [7:0]          sb_out;
   logic [8*NBYTES-1:0] st_flat;
   logic [8*NBYTES-1:0] key_flat;

   assign load = din_valid && (ph == PH_IDLE);
   assign busy = (ph != PH_IDLE);

   aesb8_ctrl #(.NBYTES(NBYTES), .NROUNDS(NROUNDS), .CW(CW), .RW(RW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .ph(ph), .cnt(cnt),
      .rnd(rnd), .rcon(rcon), .last_rnd(last_rnd)
   );

   // the one shared substitution box
   assign sb_in  = (ph == PH_MIX) ? sb_key : (s_head ^ kx);
   assign sb_out = sbox(sb_in);

   aesb8_state #(.NBYTES(NBYTES)) u_state (
      .clk(clk), .rst_n(rst_n), .ph(ph), .load(load), .din(din),
      .sub_in(sb_out), .last_rnd(last_rnd), .head(s_head), .flat(st_flat)
   );

   aesb8_key #(.NBYTES(NBYTES), .CW(CW), .RW(RW)) u_key (
      .clk(clk), .rst_n(rst_n), .ph(ph), .load(load), .key_in(key_in),
      .cnt(cnt), .rnd(rnd), .rcon(rcon), .sub_in(sb_out), .kx(kx),
      .sb_key(sb_key), .flat(key_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout       <= '0;
         dout_valid <= 1'b0;
      end else begin
         dout_valid <= (ph == PH_OUT);
         if (ph == PH_OUT) dout <= s_head ^ kx;
      end
   end

endmodule

// File: rtl/aesb8_core_chk.sv
module aesb8_core_chk #(
   parameter int NBYTES  = 16,
   parameter int NROUNDS = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                din_valid,
   input logic                busy,
   input logic                dout_valid,
   input logic [8*NBYTES-1:0] st_flat,
   input logic [8*NBYTES-1:0] key_flat
);

   localparam int LAT = NROUNDS * (NBYTES + 5) + 1;

   logic [15:0] lat;
   logic [7:0]  vrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat  <= '0;
         vrun <= '0;
      end else begin
         if (start && !busy) lat <= '0;
         else if (lat != 16'hffff) lat <= lat + 16'd1;
         vrun <= dout_valid ? vrun + 8'd1 : 8'd0;
      end
   end

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                        // R6
   AST_IDLE_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !din_valid) |=> $stable(st_flat));                       // R8
   AST_IDLE_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !din_valid) |=> $stable(key_flat));                      // R8
   AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> (busy || $past(busy)));                             // R4
   AST_VALID_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> (vrun < 8'(NBYTES)));                               // R4
   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_valid) |-> (lat == 16'(LAT)));                          // R5

endmodule

bind aesb8_core aesb8_core_chk #(.NBYTES(NBYTES), .NROUNDS(NROUNDS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .din_valid(din_valid),
   .busy(busy), .dout_valid(dout_valid), .st_flat(st_flat), .key_flat(key_flat)
);

// File: tb/aesb8_core_test.sv
module aesb8_core_test;

   localparam int CLK_P = 10;
   localparam int LAT   = 211;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] key_in = 8'h00;
   logic [7:0] din = 8'h00;
   logic       din_valid = 1'b0;
   logic [7:0] dout;
   logic       dout_valid;
   logic       busy;

   int         n_run = 0;
   int         n_fail = 0;
   int         vcount = 0;
   string      cur_tag = "R3";
   logic [7:0] exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   aesb8_core uut (
      .clk(clk), .rst_n(rst_n), .start(start), .key_in(key_in), .din(din),
      .din_valid(din_valid), .dout(dout), .dout_valid(dout_valid), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected ciphertext bytes as they appear (R3, R4)
   always @(negedge clk) begin
      if (rst_n && dout_valid) begin
         vcount++;
         if (exp_q.size() == 0) begin
            chk(1'b0, {cur_tag, " R4 unexpected byte"}, dout, 0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(dout == e, {cur_tag, " R3 ciphertext byte"}, dout, e);
         end
      end
   end

   // driver: load (R2), optional idle gap (R8), start, optional noise while busy (R7)
   task automatic run_block(input logic [127:0] key, input logic [127:0] pt,
                            input logic [127:0] ct, input int gap, input bit noisy,
                            input string tag);
      int lat;
      cur_tag = tag;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         din_valid = 1'b1;
         din       = pt[127-8*i -: 8];
         key_in    = key[127-8*i -: 8];
      end
      @(negedge clk);
      din_valid = 1'b0;
      din       = 8'h00;
      key_in    = 8'h00;
      repeat (gap) @(negedge clk);
      for (int i = 0; i < 16; i++) exp_q.push_back(ct[127-8*i -: 8]);
      vcount = 0;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {tag, " R6 busy after start"}, busy, 1);
      lat = 0;
      while (!dout_valid) begin
         if (noisy) begin
            din_valid = 1'b1;
            din       = 8'(lat * 37 + 5);
            key_in    = 8'(lat * 11 + 3);
            start     = 1'b1;
         end
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
      din_valid = 1'b0;
      start     = 1'b0;
      chk(lat == LAT, {tag, " R5 latency"}, lat, LAT);
      while (busy || dout_valid) @(negedge clk);
      chk(vcount == 16, {tag, " R4 valid cycles"}, vcount, 16);
      chk(busy == 1'b0, {tag, " R6 busy after block"}, busy, 0);
      chk(exp_q.size() == 0, {tag, " R3 bytes missing"}, exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1 busy at reset", busy, 0);
      chk(dout_valid == 1'b0, "R1 dout_valid at reset", dout_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && dout_valid == 1'b0, "R1 idle after reset", {busy, dout_valid}, 0);

      run_block(128'h000102030405060708090a0b0c0d0e0f,
                128'h00112233445566778899aabbccddeeff,
                128'h69c4e0d86a7b0430d8cdb78070b4c55a, 0, 1'b0, "R2 counting-key");
      run_block(128'h2b7e151628aed2a6abf7158809cf4f3c,
                128'h3243f6a8885a308d313198a2e0370734,
                128'h3925841d02dc09fbdc118597196a0b32, 7, 1'b1, "R8 R7 gap-and-noise");
      run_block(128'h00000000000000000000000000000000,
                128'h00000000000000000000000000000000,
                128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 0, 1'b1, "R7 zero-block");
      run_block(128'h000102030405060708090a0b0c0d0e0f,
                128'h00112233445566778899aabbccddeeff,
                128'h69c4e0d86a7b0430d8cdb78070b4c55a, 0, 1'b0, "R2 reload");

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule